// File: doc/BRIEF.md
# OFDM Subcarrier Resource Mapper

This block builds the frequency-domain input vector for one OFDM symbol at a time. It produces 512 I/Q words, one per clock, in bin order, for an inverse FFT that sits downstream. A pulse on `start` begins a symbol, and a two-bit kind code sampled with that pulse selects how the bins are filled.

On an ordinary data symbol, the block pulls QPSK words from a show-ahead FIFO. It does so only while the bin counter is inside one of the two 150-bin allocated regions, which give 300 active subcarriers in total. The DC bin and the guard band between the regions are written as zero.

On a sync symbol, the FIFO is left alone. A 31-element sequence is spread across the bins on either side of DC. The primary sequence is complex and comes in as separate real and imaginary vectors. The secondary sequence is real-only.

If the FIFO runs dry while a data bin is being built, the block emits zero for that bin and sets a flag that stays set until reset.

Top module: `ofdm_re_mapper`

## Requirements
- R1: After reset, `out_valid`, `out_first`, `fifo_rd` and `underflow` are all low.
- R2: A `start` pulse accepted while idle makes `out_valid` high for exactly 512 consecutive cycles, beginning on the clock after the accepting edge. `out_first` is high only with bin 0. A `start` seen during any bin other than the last one is ignored.
- R3: On a data symbol, FIFO words are consumed in arrival order. Words 0 to 149 land in bins 1 to 150, and words 150 to 299 land in bins 362 to 511. A FIFO word carries I in bits 31:16 and Q in bits 15:0 of the bench's packing.
- R4: On a data symbol, bin 0 and bins 151 to 361 are output as zero on both I and Q.
- R5: `fifo_rd` is high only while `fifo_empty` is low, and only during a data bin of a data symbol. The FIFO is show-ahead, so the word on `fifo_i`/`fifo_q` is the one taken.
- R6: When a data bin finds the FIFO empty, that bin is output as zero and `underflow` becomes high and stays high until reset.
- R7: Kind code 2'b00 or 2'b11 selects a data symbol, 2'b01 the primary sync symbol and 2'b10 the secondary sync symbol.
- R8: On a primary sync symbol, sequence element k (bits k*16 +: 16 of `pss_re` and `pss_im`) is placed as follows: elements 15 to 30 go in bins 1 to 16, and elements 0 to 14 go in bins 497 to 511.
- R9: On a secondary sync symbol, elements of `sss_re` take the same bins as in R8, with Q equal to zero.
- R10: On a sync symbol, no FIFO read occurs and every bin outside those named in R8 is zero.
- R11: A `start` held high during bin 511 chains the next symbol with no gap, so `out_valid` stays high across both symbols.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a symbol |
| sym_kind | input | 2 | Symbol kind code, sampled with an accepted start |
| fifo_empty | input | 1 | Data FIFO has no word |
| fifo_rd | output | 1 | Take the current FIFO word |
| fifo_i | input | 16 | In-phase part of FIFO head word |
| fifo_q | input | 16 | Quadrature part of FIFO head word |
| pss_re | input | 496 | Primary sequence, real parts, element k at k*16 |
| pss_im | input | 496 | Primary sequence, imaginary parts |
| sss_re | input | 496 | Secondary sequence values |
| out_valid | output | 1 | Output bin is valid |
| out_first | output | 1 | Output is bin 0 of a symbol |
| out_i | output | 16 | Bin in-phase value |
| out_q | output | 16 | Bin quadrature value |
| underflow | output | 1 | Sticky: a data bin found the FIFO empty |

## Verification
The assertions assume the FIFO behaves as show-ahead: `fifo_empty` changes only in response to reads or pushes, and the head word holds steady while empty is low. The bench's FIFO model updates empty and head only away from the clock edge and pops exactly once for each sampled read. The stimulus also assumes `sym_kind` is stable while `start` is high. The bench drives `start` and the kind code together at the falling edge, and changes `start` mid-symbol only in the scenario that tests it being ignored.

// File: rtl/ofdm_re_mapper.sv
module ofdm_re_mapper #(
  parameter int NBIN    = 512,
  parameter int NDATA   = 150,
  parameter int SEQ_LEN = 31,
  parameter int W       = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [1:0]           sym_kind,
  input  logic                 fifo_empty,
  output logic                 fifo_rd,
  input  logic [W-1:0]         fifo_i,
  input  logic [W-1:0]         fifo_q,
  input  logic [SEQ_LEN*W-1:0] pss_re,
  input  logic [SEQ_LEN*W-1:0] pss_im,
  input  logic [SEQ_LEN*W-1:0] sss_re,
  output logic                 out_valid,
  output logic                 out_first,
  output logic [W-1:0]         out_i,
  output logic [W-1:0]         out_q,
  output logic                 underflow
);
  localparam int BW        = $clog2(NBIN);
  localparam int SW        = $clog2(SEQ_LEN);
  localparam int HI_START  = NBIN - NDATA;
  localparam int NEG_CNT   = SEQ_LEN / 2;
  localparam int POS_CNT   = SEQ_LEN - NEG_CNT;
  localparam int NEG_START = NBIN - NEG_CNT;

  logic          busy;
  logic [BW-1:0] bin;
  logic [1:0]    kind;
  logic [SW-1:0] k;
  logic [W-1:0]  nxt_i, nxt_q;

  wire last      = busy && (bin == BW'(NBIN - 1));
  wire data_kind = (kind == 2'b00) || (kind == 2'b11);
  wire data_bin  = (bin >= BW'(1) && bin <= BW'(NDATA)) || (bin >= BW'(HI_START));
  wire in_pos    = bin >= BW'(1) && bin <= BW'(POS_CNT);
  wire in_neg    = bin >= BW'(NEG_START);
  wire take      = busy && data_kind && data_bin;

  assign fifo_rd = take && !fifo_empty;
  assign k = in_pos ? SW'(int'(bin) - 1 + NEG_CNT) : SW'(int'(bin) - NEG_START);

  always_comb begin
    nxt_i = '0;
    nxt_q = '0;
    if (busy) begin
      if (data_kind) begin
        if (fifo_rd) begin
          nxt_i = fifo_i;
          nxt_q = fifo_q;
        end
      end else if (in_pos || in_neg) begin
        if (kind == 2'b01) begin
          nxt_i = pss_re[k*W +: W];
          nxt_q = pss_im[k*W +: W];
        end else begin
          nxt_i = sss_re[k*W +: W];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      bin       <= '0;
      kind      <= 2'b00;
      out_valid <= 1'b0;
      out_first <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
      underflow <= 1'b0;
    end else begin
      out_valid <= busy;
      out_first <= busy && (bin == '0);
      out_i     <= nxt_i;
      out_q     <= nxt_q;
      if (take && fifo_empty) underflow <= 1'b1;
      if (start && (!busy || last)) begin
        busy <= 1'b1;
        bin  <= '0;
        kind <= sym_kind;
      end else if (busy) begin
        bin <= bin + 1'b1;
        if (last) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ofdm_re_mapper_chk.sv
module ofdm_re_mapper_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic [1:0] kind,
  input logic       fifo_rd,
  input logic       fifo_empty,
  input logic       out_valid,
  input logic       out_first,
  input logic       underflow
);
  a_r5_no_read_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |-> !fifo_empty);
  a_r10_sync_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (kind == 2'b01 || kind == 2'b10)) |-> !fifo_rd);
  a_r6_underflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> underflow);
  a_r6_underflow_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (!underflow && !(busy && fifo_empty)) |=> !underflow);
  a_r2_first_is_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_first |-> out_valid);
  a_r2_busy_gives_valid: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> out_valid);
  a_r2_first_once: assert property (@(posedge clk) disable iff (!rst_n)
    out_first |=> !out_first);
endmodule

bind ofdm_re_mapper ofdm_re_mapper_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .kind(kind), .fifo_rd(fifo_rd),
  .fifo_empty(fifo_empty), .out_valid(out_valid), .out_first(out_first),
  .underflow(underflow)
);

// File: tb/ofdm_re_mapper_bench.sv
`timescale 1ns/1ps
module ofdm_re_mapper_bench;
  localparam int NBIN = 512, SEQ = 31, W = 16;

  logic clk = 0, rst_n = 0, start = 0;
  logic [1:0] sym_kind = 2'b00;
  logic fifo_empty = 1, fifo_rd;
  logic [W-1:0] fifo_i = '0, fifo_q = '0;
  logic [SEQ*W-1:0] pss_re, pss_im, sss_re;
  logic out_valid, out_first, underflow;
  logic [W-1:0] out_i, out_q;

  int checks = 0, errors = 0;
  logic [31:0] fq[$];
  bit pop_pend = 0;
  int pops = 0, firsts = 0, idx = 0, streak = 0, maxstreak = 0;
  logic [W-1:0] cap_i[NBIN], cap_q[NBIN];

  always #2.5 clk = ~clk;

  ofdm_re_mapper u_ofdm_re_mapper (.*);

  always @(negedge clk) begin
    if (pop_pend && fq.size() > 0) begin void'(fq.pop_front()); pops++; end
    fifo_empty = (fq.size() == 0);
    fifo_i = fifo_empty ? '0 : fq[0][31:16];
    fifo_q = fifo_empty ? '0 : fq[0][15:0];
    if (out_valid) begin
      if (out_first) begin idx = 0; firsts++; end
      if (idx < NBIN) begin cap_i[idx] = out_i; cap_q[idx] = out_q; end
      idx++;
      streak++;
      if (streak > maxstreak) maxstreak = streak;
    end else streak = 0;
    #1 pop_pend = fifo_rd;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] entry(input int n);
    logic [W-1:0] i = W'(3*n + 1);
    logic [W-1:0] q = W'(-(5*n + 2));
    return {i, q};
  endfunction

  task automatic load(input int n, input int base);
    @(negedge clk);
    fq.delete();
    for (int j = 0; j < n; j++) fq.push_back(entry(base + j));
    pops = 0; firsts = 0; maxstreak = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic compare(input logic [1:0] kd, input int nfill, input int base);
    for (int b = 0; b < NBIN; b++) begin
      logic [W-1:0] ei = '0, eq = '0;
      string tag;
      int j = -1;
      if (kd == 2'b01 || kd == 2'b10) begin
        int kk = -1;
        tag = (kd == 2'b01) ? "R8" : "R9";
        if (b >= 1 && b <= 16) kk = b - 1 + 15;
        else if (b >= 497) kk = b - 497;
        else tag = "R10";
        if (kk >= 0) begin
          ei = (kd == 2'b01) ? pss_re[kk*W +: W] : sss_re[kk*W +: W];
          eq = (kd == 2'b01) ? pss_im[kk*W +: W] : '0;
        end
      end else begin
        tag = "R4";
        if (b >= 1 && b <= 150) j = b - 1;
        else if (b >= 362) j = 150 + b - 362;
        if (j >= 0) begin
          tag = (j < nfill) ? "R3" : "R6";
          if (j < nfill) begin
            logic [31:0] e = entry(base + j);
            ei = e[31:16]; eq = e[15:0];
          end
        end
      end
      chk(cap_i[b] == ei && cap_q[b] == eq, {tag, " bin I/Q"},
          int'({cap_i[b], cap_q[b]}), int'({ei, eq}));
    end
  endtask

  task automatic run_symbol(input logic [1:0] kd, input int nfill, input bit poke);
    load(nfill, 0);
    start = 1; sym_kind = kd;
    @(negedge clk); start = 0;
    if (poke) begin
      repeat (200) @(negedge clk);
      start = 1; @(negedge clk); start = 0;
    end
    repeat (540) @(negedge clk);
  endtask

  task automatic t_reset;
    chk(!out_valid && !out_first && !fifo_rd && !underflow, "R1 reset outputs", int'(out_valid), 0);
  endtask

  task automatic t_data;
    run_symbol(2'b00, 320, 1);
    chk(maxstreak == NBIN, "R2 valid run length", maxstreak, NBIN);
    chk(firsts == 1, "R2 first marker count", firsts, 1);
    chk(pops == 300, "R5 words consumed", pops, 300);
    chk(fq.size() == 20, "R5 words left", fq.size(), 20);
    chk(!underflow, "R6 no underflow on full fifo", int'(underflow), 0);
    compare(2'b00, 320, 0);
  endtask

  task automatic t_code3;
    run_symbol(2'b11, 300, 0);
    chk(pops == 300, "R7 code 3 acts as data", pops, 300);
    compare(2'b11, 300, 0);
  endtask

  task automatic t_sync(input logic [1:0] kd);
    run_symbol(kd, 40, 0);
    chk(pops == 0, "R10 no fifo reads on sync", pops, 0);
    chk(fq.size() == 40, "R10 fifo untouched", fq.size(), 40);
    chk(firsts == 1, "R7 sync symbol framed", firsts, 1);
    compare(kd, 0, 0);
  endtask

  task automatic t_underflow;
    chk(!underflow, "R6 flag clear before", int'(underflow), 0);
    run_symbol(2'b00, 100, 0);
    chk(underflow, "R6 flag raised", int'(underflow), 1);
    chk(pops == 100, "R6 words consumed", pops, 100);
    compare(2'b00, 100, 0);
    load(0, 0);
    chk(underflow, "R6 flag sticky", int'(underflow), 1);
  endtask

  task automatic t_chain;
    load(600, 0);
    start = 1; sym_kind = 2'b00;
    repeat (600) @(negedge clk);
    start = 0;
    repeat (500) @(negedge clk);
    chk(maxstreak == 2*NBIN, "R11 gapless chain", maxstreak, 2*NBIN);
    chk(firsts == 2, "R11 two first markers", firsts, 2);
    chk(pops == 600, "R11 words consumed", pops, 600);
    compare(2'b00, 300, 300);
  endtask

  initial begin
    for (int k = 0; k < SEQ; k++) begin
      pss_re[k*W +: W] = W'(100 + k);
      pss_im[k*W +: W] = W'(-(200 + k));
      sss_re[k*W +: W] = W'(300 + 7*k);
    end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_data();
    t_code3();
    t_sync(2'b01);
    t_sync(2'b10);
    t_underflow();
    t_chain();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule